// File: doc/BRIEF.md
# Four-Channel Match Timer

A memory-mapped timer block with four 32-bit counters. All counters are paced by one shared prescaler, and each counter has its own compare value. A simple synchronous register bus writes and reads the registers. Every register also has three alias addresses. These alias addresses set, clear or toggle selected bits in a single bus write, so software never needs a read-modify-write sequence.

Each channel has the following controls:
- an enable bit;
- a synchronous hold-at-zero (reset) bit;
- a direction code;
- a three-bit action field that picks what a compare hit does: raise a flag, return the counter to zero, and/or stop the counter by clearing its enable bit.

Flags are cleared by writing ones to them. A single interrupt line is high whenever any flag is set.

Register slots are 16 bytes apart: `bus_addr[7:4]` selects the register and `bus_addr[3:2]` selects the access kind. The slot map is:
- 0x00: flags
- 0x10: control
- 0x20: direction
- 0x30 to 0x60: counters 0 to 3
- 0x70: prescale value
- 0x80: prescale counter
- 0x90: action fields
- 0xA0 to 0xD0: compare values 0 to 3

Top module: `match_timer4`

## Requirements
- R1: A write at slot offset +0x0 replaces the register, +0x4 ORs in the written ones, +0x8 clears the written ones, and +0xC inverts the written ones. A read at any of the four offsets returns the register.
- R2: Bus writes to the counter slots and the prescale-counter slot have no effect. These slots are read-only.
- R3: In the control register, bit n (n = 0..3) enables counter n. A disabled counter holds its value. With a prescale value of 0, an enabled counter moves by one on every clock edge.
- R4: With prescale value P, the prescale counter runs 0,1..P and wraps to 0. Enabled counters move once each time it wraps, which is once every P+1 clocks.
- R5: Control bit 4+n set to 1 zeroes counter n and the prescale counter on the next edge. The counter stays at zero while the bit remains 1, and counting resumes after the bit is cleared.
- R6: Direction bits [4n+1:4n] select how counter n moves. Code 01 counts down; codes 00, 10 and 11 count up.
- R7: A compare hit is a counting tick on which an enabled counter equals its compare value. If action bit 3n is set, a hit on channel n sets flag bit n.
- R8: If action bit 3n+1 is set, a hit loads counter n with 0 instead of moving it.
- R9: If action bit 3n+2 is set, a hit clears enable bit n, and counter n then holds its value.
- R10: A write at the flag slot's base offset clears each flag bit written as 1. Flag bits written as 0 are left as they are.
- R11: A counter crossing between 0xFFFFFFFF and 0x00000000 in either direction sets no flag.
- R12: `irq_o` is high exactly when at least one flag bit is set.
- R13: After reset, every register reads zero and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 8 | Byte address: slot in [7:4], access kind in [3:2] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed slot (combinational) |
| irq_o | output | 1 | High while any flag is set |

## Verification
The bench targets the edges where an off-by-one would appear:
- **Compare hit cycle.** The flag and the zero reload must appear one tick after the counter reaches its compare value. A design that compared the next value instead would flag one cycle early and give a period one count short.
- **Prescaler wrap.** Using P = 3 exposes a prescaler that divides by P instead of P+1.
- **Down-count wrap.** Counting down through zero with the interrupt action armed on another value catches a design that treats the wrap as an event.
- **Stop action.** The bench reads back the control register after a hit. A design that only froze the counter without clearing the enable bit would show enable still set.
- **Flag clearing.** Two flags are raised and then cleared one at a time. This shows whether a base-offset write clears only the bits written as 1, or overwrites the whole register.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;

    localparam int DATA_W = 32;
    localparam int SLOT_W = 4;

    // Access kind carried in bus_addr[3:2]
    typedef enum logic [1:0] {
        OP_WRITE  = 2'd0,
        OP_SET    = 2'd1,
        OP_CLEAR  = 2'd2,
        OP_TOGGLE = 2'd3
    } alias_op_e;

    typedef enum logic [1:0] {
        DIR_UP    = 2'b00,
        DIR_DOWN  = 2'b01,
        DIR_UP_B  = 2'b10,
        DIR_UP_C  = 2'b11
    } dir_code_e;

    // Per-channel action field, bit 0 = flag, bit 1 = zero, bit 2 = stop
    typedef struct packed {
        logic stop;
        logic zero;
        logic flag;
    } match_act_t;

    typedef struct packed {
        logic                wr;
        alias_op_e           op;
        logic [SLOT_W-1:0]   slot;
        logic [DATA_W-1:0]   data;
    } bus_wr_t;

    function automatic logic [DATA_W-1:0] apply_op(
        input alias_op_e         op,
        input logic [DATA_W-1:0] cur,
        input logic [DATA_W-1:0] wd
    );
        case (op)
            OP_SET:    return cur | wd;
            OP_CLEAR:  return cur & ~wd;
            OP_TOGGLE: return cur ^ wd;
            default:   return wd;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] step_count(
        input logic [DATA_W-1:0] v,
        input logic              down
    );
        return down ? (v - DATA_W'(1)) : (v + DATA_W'(1));
    endfunction

endpackage

// File: rtl/mtmr_decode.sv
module mtmr_decode
    import mtmr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output bus_wr_t              wr,
    output logic [SLOT_W-1:0]    rd_slot
);
    localparam int SLOT_LSB = 4;

    logic unused_addr_bits;
    assign unused_addr_bits = ^bus_addr[1:0];

    always_comb begin
        wr.wr   = bus_sel && bus_we;
        wr.op   = alias_op_e'(bus_addr[3:2]);
        wr.slot = bus_addr[SLOT_LSB +: SLOT_W];
        wr.data = bus_wdata;
    end

    assign rd_slot = bus_addr[SLOT_LSB +: SLOT_W];

endmodule

// File: rtl/mtmr_prescaler.sv
module mtmr_prescaler
    import mtmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              clr,
    input  logic [DATA_W-1:0] limit,
    output logic [DATA_W-1:0] pc,
    output logic              tick
);
    logic [DATA_W-1:0] pc_q;
    logic              at_end;

    assign at_end = (pc_q >= limit);
    assign tick   = run && !clr && at_end;
    assign pc     = pc_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pc_q <= '0;
        end else if (run) begin
            pc_q <= at_end ? '0 : (pc_q + DATA_W'(1));
        end
    end

endmodule

// File: rtl/mtmr_channel.sv
module mtmr_channel
    import mtmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              hold,
    input  logic              down,
    input  logic              tick,
    input  logic [DATA_W-1:0] cmp,
    input  match_act_t        act,
    output logic [DATA_W-1:0] cnt,
    output logic              hit_flag,
    output logic              stop_req
);
    logic [DATA_W-1:0] cnt_q;
    logic              hit;

    assign hit      = tick && en && !hold && (cnt_q == cmp);
    assign hit_flag = hit && act.flag;
    assign stop_req = hit && act.stop;
    assign cnt      = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            cnt_q <= '0;
        end else if (tick && en) begin
            if (hit && act.zero) begin
                cnt_q <= '0;
            end else if (hit && act.stop) begin
                cnt_q <= cnt_q;
            end else begin
                cnt_q <= step_count(cnt_q, down);
            end
        end
    end

endmodule

// File: rtl/mtmr_regs.sv
module mtmr_regs
    import mtmr_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                             clk,
    input  logic                             rst,
    input  bus_wr_t                          wr,
    input  logic [SLOT_W-1:0]                rd_slot,
    input  logic [NUM_CH-1:0][DATA_W-1:0]    cnt,
    input  logic [DATA_W-1:0]                pc,
    input  logic [NUM_CH-1:0]                hit_flag,
    input  logic [NUM_CH-1:0]                stop_req,
    output logic [NUM_CH-1:0]                en,
    output logic [NUM_CH-1:0]                hold,
    output logic [NUM_CH-1:0]                down,
    output logic [NUM_CH-1:0]                flags,
    output logic [DATA_W-1:0]                pr,
    output match_act_t [NUM_CH-1:0]          act,
    output logic [NUM_CH-1:0][DATA_W-1:0]    cmp,
    output logic [DATA_W-1:0]                rdata
);
    localparam int S_FLAG = 0;
    localparam int S_CTRL = 1;
    localparam int S_DIR  = 2;
    localparam int S_CNT0 = 3;
    localparam int S_PR   = S_CNT0 + NUM_CH;
    localparam int S_PC   = S_PR + 1;
    localparam int S_ACT  = S_PC + 1;
    localparam int S_CMP0 = S_ACT + 1;
    localparam int CTRL_W = 2 * NUM_CH;
    localparam int ACT_W  = 3 * NUM_CH;
    localparam int DIR_STRIDE = 4;

    logic [CTRL_W-1:0]              ctrl_q, ctrl_d;
    logic [NUM_CH-1:0][1:0]         dir_q, dir_d;
    logic [NUM_CH-1:0]              flag_q, flag_d;
    logic [DATA_W-1:0]              pr_q, pr_d;
    logic [ACT_W-1:0]               act_q, act_d;
    logic [NUM_CH-1:0][DATA_W-1:0]  cmp_q, cmp_d;

    logic [DATA_W-1:0] ctrl_x, dir_x, flag_x, act_x;
    logic [DATA_W-1:0] ctrl_new, dir_new, flag_new, act_new;
    alias_op_e         flag_op;

    function automatic logic slot_hit(input bus_wr_t w, input int s);
        return w.wr && (w.slot == SLOT_W'(s));
    endfunction

    // zero-extended views of the narrow registers
    always_comb begin
        ctrl_x = '0;
        ctrl_x[CTRL_W-1:0] = ctrl_q;
        flag_x = '0;
        flag_x[NUM_CH-1:0] = flag_q;
        act_x = '0;
        act_x[ACT_W-1:0] = act_q;
        dir_x = '0;
        for (int n = 0; n < NUM_CH; n++) begin
            dir_x[DIR_STRIDE*n +: 2] = dir_q[n];
        end
    end

    // base offset on the flag slot clears written ones
    assign flag_op  = (wr.op == OP_WRITE) ? OP_CLEAR : wr.op;
    assign ctrl_new = apply_op(wr.op, ctrl_x, wr.data);
    assign dir_new  = apply_op(wr.op, dir_x, wr.data);
    assign flag_new = apply_op(flag_op, flag_x, wr.data);
    assign act_new  = apply_op(wr.op, act_x, wr.data);

    logic unused_upper;
    assign unused_upper = ^{ctrl_new, dir_new, flag_new, act_new};

    always_comb begin
        ctrl_d = ctrl_q;
        dir_d  = dir_q;
        flag_d = flag_q;
        pr_d   = pr_q;
        act_d  = act_q;
        cmp_d  = cmp_q;
        if (slot_hit(wr, S_CTRL)) ctrl_d = ctrl_new[CTRL_W-1:0];
        if (slot_hit(wr, S_DIR)) begin
            for (int n = 0; n < NUM_CH; n++) begin
                dir_d[n] = dir_new[DIR_STRIDE*n +: 2];
            end
        end
        if (slot_hit(wr, S_FLAG)) flag_d = flag_new[NUM_CH-1:0];
        if (slot_hit(wr, S_PR))   pr_d   = apply_op(wr.op, pr_q, wr.data);
        if (slot_hit(wr, S_ACT))  act_d  = act_new[ACT_W-1:0];
        for (int n = 0; n < NUM_CH; n++) begin
            if (slot_hit(wr, S_CMP0 + n)) cmp_d[n] = apply_op(wr.op, cmp_q[n], wr.data);
        end
        // hardware events take priority over a same-cycle bus write
        ctrl_d[NUM_CH-1:0] = ctrl_d[NUM_CH-1:0] & ~stop_req;
        flag_d = flag_d | hit_flag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            dir_q  <= '0;
            flag_q <= '0;
            pr_q   <= '0;
            act_q  <= '0;
            cmp_q  <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            dir_q  <= dir_d;
            flag_q <= flag_d;
            pr_q   <= pr_d;
            act_q  <= act_d;
            cmp_q  <= cmp_d;
        end
    end

    assign en    = ctrl_q[NUM_CH-1:0];
    assign hold  = ctrl_q[CTRL_W-1:NUM_CH];
    assign flags = flag_q;
    assign pr    = pr_q;
    assign act   = act_q;
    assign cmp   = cmp_q;

    always_comb begin
        for (int n = 0; n < NUM_CH; n++) begin
            down[n] = (dir_code_e'(dir_q[n]) == DIR_DOWN);
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_slot == SLOT_W'(S_FLAG)) rdata = flag_x;
        if (rd_slot == SLOT_W'(S_CTRL)) rdata = ctrl_x;
        if (rd_slot == SLOT_W'(S_DIR))  rdata = dir_x;
        if (rd_slot == SLOT_W'(S_PR))   rdata = pr_q;
        if (rd_slot == SLOT_W'(S_PC))   rdata = pc;
        if (rd_slot == SLOT_W'(S_ACT))  rdata = act_x;
        for (int n = 0; n < NUM_CH; n++) begin
            if (rd_slot == SLOT_W'(S_CNT0 + n)) rdata = cnt[n];
            if (rd_slot == SLOT_W'(S_CMP0 + n)) rdata = cmp_q[n];
        end
    end

endmodule

// File: rtl/match_timer4.sv
module match_timer4
    import mtmr_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o
);
    bus_wr_t                         wr_w;
    logic [SLOT_W-1:0]               rd_slot_w;
    logic [NUM_CH-1:0][DATA_W-1:0]   cnt_w;
    logic [NUM_CH-1:0][DATA_W-1:0]   cmp_w;
    logic [DATA_W-1:0]               pc_w;
    logic [DATA_W-1:0]               pr_w;
    logic [NUM_CH-1:0]               en_w, hold_w, down_w, flags_w;
    logic [NUM_CH-1:0]               hit_flag_w, stop_req_w;
    match_act_t [NUM_CH-1:0]         act_w;
    logic                            tick_w;

    mtmr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .wr        (wr_w),
        .rd_slot   (rd_slot_w)
    );

    mtmr_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr_w),
        .rd_slot  (rd_slot_w),
        .cnt      (cnt_w),
        .pc       (pc_w),
        .hit_flag (hit_flag_w),
        .stop_req (stop_req_w),
        .en       (en_w),
        .hold     (hold_w),
        .down     (down_w),
        .flags    (flags_w),
        .pr       (pr_w),
        .act      (act_w),
        .cmp      (cmp_w),
        .rdata    (bus_rdata)
    );

    mtmr_prescaler u_presc (
        .clk   (clk),
        .rst   (rst),
        .run   (|en_w),
        .clr   (|hold_w),
        .limit (pr_w),
        .pc    (pc_w),
        .tick  (tick_w)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        mtmr_channel u_ch (
            .clk      (clk),
            .rst      (rst),
            .en       (en_w[n]),
            .hold     (hold_w[n]),
            .down     (down_w[n]),
            .tick     (tick_w),
            .cmp      (cmp_w[n]),
            .act      (act_w[n]),
            .cnt      (cnt_w[n]),
            .hit_flag (hit_flag_w[n]),
            .stop_req (stop_req_w[n])
        );
    end

    assign irq_o = |flags_w;

endmodule

// File: rtl/mtmr_checker.sv
module mtmr_checker
    import mtmr_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            tick,
    input logic [DATA_W-1:0]               pc,
    input logic [NUM_CH-1:0]               en,
    input logic [NUM_CH-1:0]               hold,
    input logic [NUM_CH-1:0]               flags,
    input logic [3*NUM_CH-1:0]             act,
    input logic [NUM_CH-1:0][DATA_W-1:0]   cnt,
    input logic [NUM_CH-1:0][DATA_W-1:0]   cmp
);
    AST_PC_WRAPS: assert property (@(posedge clk) disable iff (rst) tick |=> (pc == '0)); // R4

    for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
        AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (rst)
            hold[n] |=> (cnt[n] == '0)); // R5
        AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
            (!en[n] && !hold[n]) |=> $stable(cnt[n])); // R3
        AST_HIT_FLAG: assert property (@(posedge clk) disable iff (rst)
            (tick && en[n] && !hold[n] && cnt[n] == cmp[n] && act[3*n]) |=> flags[n]); // R7
        AST_HIT_ZERO: assert property (@(posedge clk) disable iff (rst)
            (tick && en[n] && !hold[n] && cnt[n] == cmp[n] && act[3*n+1]) |=> (cnt[n] == '0)); // R8
        AST_HIT_STOP: assert property (@(posedge clk) disable iff (rst)
            (tick && en[n] && !hold[n] && cnt[n] == cmp[n] && act[3*n+2]) |=> !en[n]); // R9
    end

endmodule

bind match_timer4 mtmr_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick_w),
    .pc    (pc_w),
    .en    (en_w),
    .hold  (hold_w),
    .flags (flags_w),
    .act   (act_w),
    .cnt   (cnt_w),
    .cmp   (cmp_w)
);

// File: tb/sim_match_timer4.sv
`timescale 1ns/1ps
module sim_match_timer4;

    localparam logic [7:0] A_FLAG = 8'h00;
    localparam logic [7:0] A_CTRL = 8'h10;
    localparam logic [7:0] A_DIR  = 8'h20;
    localparam logic [7:0] A_CNT0 = 8'h30;
    localparam logic [7:0] A_PR   = 8'h70;
    localparam logic [7:0] A_PC   = 8'h80;
    localparam logic [7:0] A_ACT  = 8'h90;
    localparam logic [7:0] A_CMP0 = 8'hA0;
    localparam logic [7:0] K_SET  = 8'h4;
    localparam logic [7:0] K_CLR  = 8'h8;
    localparam logic [7:0] K_TGL  = 8'hC;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    match_timer4 u0 (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic wait_edges(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        wait_edges(3);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        rd(A_CTRL, v); chk("R13 ctrl", v, 0);
        rd(A_ACT, v);  chk("R13 act", v, 0);
        rd(A_PR, v);   chk("R13 prescale", v, 0);
        rd(A_CNT0 + 8'h30, v); chk("R13 cnt3", v, 0);
        rd(A_FLAG, v); chk("R13 flags", v, 0);
        chk("R13 irq", 32'(irq_o), 0);
    endtask

    task automatic t_alias();
        logic [31:0] v;
        do_reset();
        wr(A_ACT, 32'h5);          rd(A_ACT, v); chk("R1 base write", v, 32'h5);
        wr(A_ACT + K_SET, 32'h2);  rd(A_ACT, v); chk("R1 set alias", v, 32'h7);
        wr(A_ACT + K_CLR, 32'h1);  rd(A_ACT, v); chk("R1 clear alias", v, 32'h6);
        wr(A_ACT + K_TGL, 32'h3);  rd(A_ACT, v); chk("R1 toggle alias", v, 32'h5);
        rd(A_ACT + K_SET, v);      chk("R1 read via alias", v, 32'h5);
        wr(A_CMP0 + 8'h10, 32'hF0F0_0000);
        wr(A_CMP0 + 8'h10 + K_TGL, 32'hFFFF_0001);
        rd(A_CMP0 + 8'h10, v);     chk("R1 toggle compare", v, 32'h0F0F_0001);
    endtask

    task automatic t_readonly();
        logic [31:0] v;
        do_reset();
        wr(A_CNT0, 32'h55);
        wr(A_PC, 32'h7);
        wr(A_CNT0 + K_SET, 32'hFF);
        rd(A_CNT0, v); chk("R2 counter write ignored", v, 0);
        rd(A_PC, v);   chk("R2 prescale counter write ignored", v, 0);
    endtask

    task automatic t_count();
        logic [31:0] v;
        do_reset();
        wait_edges(4);
        rd(A_CNT0, v); chk("R3 disabled holds", v, 0);
        wr(A_CTRL, 32'h1);
        wait_edges(10);
        rd(A_CNT0, v); chk("R3 counts each clock", v, 10);
        rd(A_CNT0 + 8'h10, v); chk("R3 other channel idle", v, 0);
        wr(A_CTRL + K_CLR, 32'h1);
        wait_edges(5);
        rd(A_CNT0, v); chk("R3 holds after disable", v, 11);
    endtask

    task automatic t_prescale();
        logic [31:0] v;
        do_reset();
        wr(A_PR, 32'd3);
        wr(A_CTRL, 32'h2);
        wait_edges(8);
        rd(A_CNT0 + 8'h10, v); chk("R4 count at P=3", v, 2);
        rd(A_PC, v);           chk("R4 prescale wrapped", v, 0);
        wait_edges(2);
        rd(A_PC, v);           chk("R4 prescale mid", v, 2);
        rd(A_CNT0 + 8'h10, v); chk("R4 count between ticks", v, 2);
    endtask

    task automatic t_hold();
        logic [31:0] v;
        do_reset();
        wr(A_CTRL, 32'h1);
        wait_edges(6);
        wr(A_CTRL + K_SET, 32'h10);
        wait_edges(1);
        rd(A_CNT0, v); chk("R5 zeroed by hold bit", v, 0);
        wait_edges(3);
        rd(A_CNT0, v); chk("R5 stays zero", v, 0);
        wr(A_CTRL + K_CLR, 32'h10);
        wait_edges(4);
        rd(A_CNT0, v); chk("R5 resumes", v, 4);
    endtask

    task automatic t_dir_wrap();
        logic [31:0] v;
        do_reset();
        wr(A_CMP0 + 8'h10, 32'h100);
        wr(A_ACT, 32'h8);            // channel 1 flag action
        wr(A_DIR, 32'h210);          // ch1 = 01 down, ch2 = 10 up
        rd(A_DIR, v); chk("R6 direction readback", v, 32'h210);
        wr(A_CTRL, 32'h6);
        wait_edges(5);
        rd(A_CNT0 + 8'h10, v); chk("R6 down count", v, 32'hFFFF_FFFB);
        rd(A_CNT0 + 8'h20, v); chk("R6 code 10 counts up", v, 5);
        rd(A_FLAG, v);         chk("R11 no flag on wrap", v, 0);
        chk("R11 irq low after wrap", 32'(irq_o), 0);
    endtask

    task automatic t_flags();
        logic [31:0] v;
        do_reset();
        wr(A_CMP0, 32'd5);
        wr(A_CMP0 + 8'h30, 32'd2);
        wr(A_ACT, 32'h201);          // ch0 and ch3 flag action
        wr(A_CTRL, 32'h9);
        wait_edges(2);
        rd(A_FLAG, v); chk("R7 no flag before hit", v, 0);
        wait_edges(1);
        rd(A_FLAG, v); chk("R7 ch3 flag", v, 32'h8);
        wait_edges(2);
        rd(A_FLAG, v); chk("R7 ch0 not yet", v, 32'h8);
        wait_edges(1);
        rd(A_FLAG, v); chk("R7 both flags", v, 32'h9);
        chk("R12 irq high", 32'(irq_o), 1);
        wr(A_CTRL + K_CLR, 32'h9);
        wr(A_FLAG, 32'h1);
        rd(A_FLAG, v); chk("R10 clears only written one", v, 32'h8);
        chk("R12 irq with one flag", 32'(irq_o), 1);
        wr(A_FLAG, 32'h8);
        rd(A_FLAG, v); chk("R10 all cleared", v, 0);
        chk("R12 irq low", 32'(irq_o), 0);
    endtask

    task automatic t_zero();
        logic [31:0] v;
        do_reset();
        wr(A_CMP0, 32'd3);
        wr(A_ACT, 32'h2);
        wr(A_CTRL, 32'h1);
        wait_edges(4);
        rd(A_CNT0, v); chk("R8 reload to zero", v, 0);
        wait_edges(3);
        rd(A_CNT0, v); chk("R8 second period top", v, 3);
        wait_edges(1);
        rd(A_CNT0, v); chk("R8 second reload", v, 0);
        rd(A_FLAG, v); chk("R8 no flag without flag action", v, 0);
    endtask

    task automatic t_stop();
        logic [31:0] v;
        do_reset();
        wr(A_CMP0 + 8'h20, 32'd4);
        wr(A_ACT, 32'h100);          // ch2 stop action
        wr(A_CTRL, 32'h4);
        wait_edges(5);
        rd(A_CTRL, v);         chk("R9 enable cleared", v, 0);
        rd(A_CNT0 + 8'h20, v); chk("R9 counter holds", v, 4);
        wait_edges(5);
        rd(A_CNT0 + 8'h20, v); chk("R9 still held", v, 4);
    endtask

    initial begin
        t_reset();
        t_alias();
        t_readonly();
        t_count();
        t_prescale();
        t_hold();
        t_dir_wrap();
        t_flags();
        t_zero();
        t_stop();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule